// File: doc/BRIEF.md
# Buffered-Reload PWM Generator

This block produces edge-aligned pulse-width outputs from an up-only period counter. Software writes the period limit, one duty value per output and a prescaler code into shadow registers, then arms a transfer with a load-permit bit. The shadow contents reach the working registers only at two moments: the rising edge of the enable input, or a reload opportunity at the end of a period. Each transfer clears the permit bit, so software must arm every update explicitly.

Reload opportunities occur once every N+1 periods, where N is the reload-spacing field. Every enable rise and every reload opportunity raise a reload flag. The interrupt line is the flag gated by an interrupt-enable input. While the generator is off, every output has its output-enable low, so the pins can float. Working registers come out of reset with divisor one, duty zero and a fixed period limit. A generator started without an armed transfer therefore runs on these defaults. On a later restart it runs on whatever values it last took in.

Top module: `pwm_reload_gen`

## Requirements
- R1: After reset all outputs and output-enables are low, the reload flag is 0, the load permit is 0 and the interrupt line is low.
- R2: Output-enables and outputs are low in the cycle after enable is sampled low. Output-enables are high from the cycle after enable is sampled high.
- R3: On an enable rise with the load permit set, the shadow period limit, duties and prescaler code are in use from the first count, and the load permit reads 0 afterwards.
- R4: On an enable rise with the permit clear and no earlier transfer, the generator runs with duty zero on every output, so all outputs stay low while output-enables are high.
- R5: Every enable rise sets the reload flag.
- R6: The interrupt line equals the reload flag gated by the interrupt-enable input.
- R7: A clear pulse zeroes the reload flag. A set in the same cycle wins over the clear.
- R8: The count runs 1, 2, …, limit, then returns to 1. An output is high while the count is at or below its duty. With limit 3 and duty 2 the pattern is high, high, low, repeating.
- R9: With reload spacing 0, a permit armed during a period makes the shadow values take effect from the next period. Shadow writes without the permit never change the output.
- R10: With reload spacing N (register address 2), a transfer takes effect from period N+1, counting the first period after enable as period 0.
- R11: Re-enabling with the permit clear resumes with the last values transferred.
- R12: A duty of zero holds an output low. A duty at or above the limit holds it high for the whole period.
- R13: A prescaler code p (register address 1) makes the count advance once every 2^p clocks. The register addresses are 0 for the limit, 1 for the prescaler code, 2 for the reload spacing and 3+i for the duty of output i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 limit, 1 prescaler, 2 spacing, 3+i duty i) |
| wr_data | input | 16 | Register write data |
| run_en | input | 1 | Generator enable level |
| arm_set | input | 1 | Pulse that sets the load permit |
| flag_clr | input | 1 | Pulse that clears the reload flag |
| irq_en | input | 1 | Interrupt enable |
| pwm_o | output | 2 | PWM outputs |
| pwm_oe | output | 2 | Output-enables (low means high-impedance) |
| arm_o | output | 1 | Load permit state |
| rld_flag | output | 1 | Reload flag |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the embedded properties check the following. An output is never high while its enable is low. The count never reaches zero, and the prescaler phase stays under its limit. An enable rise always leaves the flag set. A transfer always consumes the permit. The working period limit moves only on a transfer. Only the scenarios can show which values are in use in which period: the enable-time default load, the resume after re-enable, the shift of a mid-run update to the right period boundary for spacing 0 and spacing 2, and the stretched count under a prescaler. The bench scoreboards these scenarios cycle by cycle against an independently computed waveform.

// File: rtl/pwm_reload_pkg.sv
// Shared register map for the buffered-reload PWM generator.
// Assumes duty registers occupy consecutive addresses from REG_DUTY0.
package pwm_reload_pkg;
    localparam int REG_LIMIT = 0;
    localparam int REG_PRE   = 1;
    localparam int REG_SPACE = 2;
    localparam int REG_DUTY0 = 3;
endpackage

// File: rtl/pwm_prescaler.sv
// Divides the clock by 2^code and emits a one-cycle count tick.
// Assumes code changes only together with restart or right after a tick.
module pwm_prescaler #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int PW = (1 << PRE_W) - 1;

    logic [PW-1:0] phase;
    logic [PW-1:0] lim;

    // terminal phase for the selected divisor
    always_comb lim = PW'((32'd1 << code) - 32'd1);
    assign tick = run && (phase == lim);

    // phase counter, cleared on start and on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (restart) phase <= '0;
        else if (tick)    phase <= '0;
        else if (run)     phase <= phase + 1'b1;
    end

    // R13
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> phase <= lim);
endmodule

// File: rtl/pwm_period_counter.sv
// Up-only period counter 1..limit plus the reload-spacing counter.
// Assumes a limit of zero behaves like one.
module pwm_period_counter #(
    parameter int CNT_W = 16,
    parameter int SPC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic [SPC_W-1:0] spacing,
    output logic [CNT_W-1:0] count,
    output logic             reload_pt
);
    logic             wrap;
    logic [SPC_W-1:0] gap;

    assign wrap      = tick && (count >= limit);
    assign reload_pt = wrap && (gap >= spacing);

    // period count, restarted at 1
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= CNT_W'(1);
        else if (restart) count <= CNT_W'(1);
        else if (wrap)    count <= CNT_W'(1);
        else if (tick)    count <= count + 1'b1;
    end

    // periods elapsed since the last reload opportunity
    always_ff @(posedge clk) begin
        if (!rst_n)         gap <= '0;
        else if (restart)   gap <= '0;
        else if (reload_pt) gap <= '0;
        else if (wrap)      gap <= gap + 1'b1;
    end

    // R8
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0);
endmodule

// File: rtl/pwm_reload_ctrl.sv
// Shadow and working registers, load permit, reload flag and enable edge.
// Assumes one register write per cycle; the spacing field is not shadowed.
module pwm_reload_ctrl
    import pwm_reload_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter int               PRE_W   = 2,
    parameter int               SPC_W   = 4,
    parameter int               N_OUT   = 2,
    parameter int               ADDR_W  = 3,
    parameter logic [CNT_W-1:0] LIM_RST = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic                        run_en,
    input  logic                        arm_set,
    input  logic                        flag_clr,
    input  logic                        reload_pt,
    output logic                        running,
    output logic                        restart,
    output logic [CNT_W-1:0]            lim_act,
    output logic [PRE_W-1:0]            pre_act,
    output logic [N_OUT-1:0][CNT_W-1:0] duty_act,
    output logic [SPC_W-1:0]            spacing,
    output logic                        arm_q,
    output logic                        flag_q
);
    logic [CNT_W-1:0]            lim_sh;
    logic [PRE_W-1:0]            pre_sh;
    logic [N_OUT-1:0][CNT_W-1:0] duty_sh;
    logic                        load;

    assign restart = run_en && !running;
    assign load    = (restart || reload_pt) && arm_q;

    // registered enable
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= run_en;
    end

    // shadow limit, prescaler and spacing writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_sh  <= '0;
            pre_sh  <= '0;
            spacing <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_LIMIT)) lim_sh  <= wr_data;
            if (wr_addr == ADDR_W'(REG_PRE))   pre_sh  <= wr_data[PRE_W-1:0];
            if (wr_addr == ADDR_W'(REG_SPACE)) spacing <= wr_data[SPC_W-1:0];
        end
    end

    // per-output shadow duty and working duty
    for (genvar i = 0; i < N_OUT; i++) begin : g_duty
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_sh[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(REG_DUTY0 + i))
                duty_sh[i] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    duty_act[i] <= '0;
            else if (load) duty_act[i] <= duty_sh[i];
        end
    end

    // working limit and prescaler, loaded only on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_act <= LIM_RST;
            pre_act <= '0;
        end else if (load) begin
            lim_act <= lim_sh;
            pre_act <= pre_sh;
        end
    end

    // load permit: set by software, consumed by a transfer
    always_ff @(posedge clk) begin
        if (!rst_n)       arm_q <= 1'b0;
        else if (arm_set) arm_q <= 1'b1;
        else if (load)    arm_q <= 1'b0;
    end

    // reload flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (restart || reload_pt) flag_q <= 1'b1;
        else if (flag_clr)             flag_q <= 1'b0;
    end

    // R5
    flag_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> flag_q);
    // R3
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !arm_set) |=> !arm_q);
    // R9
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lim_act));
endmodule

// File: rtl/pwm_reload_gen.sv
// Top of the buffered-reload PWM generator: compares the period count
// against each working duty, gates the outputs with the enable state and
// forms the interrupt. Assumes synchronous, single-clock use.
module pwm_reload_gen
    import pwm_reload_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter int               PRE_W   = 2,
    parameter int               SPC_W   = 4,
    parameter int               N_OUT   = 2,
    parameter logic [CNT_W-1:0] LIM_RST = '1,
    localparam int              ADDR_W  = $clog2(REG_DUTY0 + N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              run_en,
    input  logic              arm_set,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic [N_OUT-1:0]  pwm_o,
    output logic [N_OUT-1:0]  pwm_oe,
    output logic              arm_o,
    output logic              rld_flag,
    output logic              irq
);
    logic                        running, restart, tick, reload_pt;
    logic [CNT_W-1:0]            lim_act, count;
    logic [PRE_W-1:0]            pre_act;
    logic [N_OUT-1:0][CNT_W-1:0] duty_act;
    logic [SPC_W-1:0]            spacing;

    pwm_reload_ctrl #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .SPC_W(SPC_W), .N_OUT(N_OUT),
        .ADDR_W(ADDR_W), .LIM_RST(LIM_RST)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run_en(run_en), .arm_set(arm_set),
        .flag_clr(flag_clr), .reload_pt(reload_pt), .running(running),
        .restart(restart), .lim_act(lim_act), .pre_act(pre_act),
        .duty_act(duty_act), .spacing(spacing), .arm_q(arm_o),
        .flag_q(rld_flag)
    );

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(restart),
        .code(pre_act), .tick(tick)
    );

    pwm_period_counter #(.CNT_W(CNT_W), .SPC_W(SPC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .limit(lim_act), .spacing(spacing), .count(count),
        .reload_pt(reload_pt)
    );

    // interrupt is the flag gated by its enable
    assign irq = rld_flag && irq_en;

    // per-output compare and output-enable
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign pwm_oe[i] = running;
        assign pwm_o[i]  = running && (count <= duty_act[i]);

        // R2
        off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_oe[i] |-> !pwm_o[i]);
    end
endmodule

// File: tb/tb_pwm_reload_gen.sv
module tb_pwm_reload_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        run_en = 1'b0, arm_set = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
    logic [1:0]  pwm_o, pwm_oe;
    logic        arm_o, rld_flag, irq;

    always #2 clk = ~clk;

    pwm_reload_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run_en(run_en), .arm_set(arm_set),
        .flag_clr(flag_clr), .irq_en(irq_en), .pwm_o(pwm_o),
        .pwm_oe(pwm_oe), .arm_o(arm_o), .rld_flag(rld_flag), .irq(irq)
    );

    typedef struct {
        logic [1:0] pwm;
        logic       oe;
        string      req;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected waveform: limit lim, divisor div, output 0 duty da before
    // period sw and db from it on, output 1 duty d1
    task automatic push_run(input int lim, input int div, input int da,
                            input int db, input int sw, input int d1,
                            input int n, input string req);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            int per = (k / div) / lim;
            int c = ((k / div) % lim) + 1;
            int d0 = (per >= sw) ? db : da;
            e.pwm = {c <= d1, c <= d0};
            e.oe = 1'b1;
            e.req = req;
            q.push_back(e);
        end
    endtask

    // monitor: compares one expected item per cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(32'(pwm_o), 32'(e.pwm), e.req, "pwm_o");
                check(32'(pwm_oe), {30'd0, e.oe, e.oe}, e.req, "pwm_oe");
            end
        end
    end

    task automatic wr(input int addr, input int data, input logic arm);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data); arm_set = arm;
        @(negedge clk);
        wr_en = 1'b0; arm_set = 1'b0;
    endtask

    task automatic stop_run();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(32'(pwm_oe), 0, "R2", "oe after disable");
        check(32'(pwm_o), 0, "R2", "pwm after disable");
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(32'(pwm_o), 0, "R1", "pwm_o");
        check(32'(pwm_oe), 0, "R1", "pwm_oe");
        check(32'(rld_flag), 0, "R1", "flag");
        check(32'(arm_o), 0, "R1", "permit");
        check(32'(irq), 0, "R1", "irq");

        wr(0, 3, 1'b0);
        wr(3, 2, 1'b0);
        wr(4, 5, 1'b0);

        // R4: first enable without permit runs on default duty zero
        run_en = 1'b1;
        push_run(3, 1, 0, 0, 0, 0, 8, "R4");
        @(negedge clk);
        check(32'(rld_flag), 1, "R5", "flag after enable");
        check(32'(irq), 0, "R6", "irq masked");
        irq_en = 1'b1;
        @(negedge clk);
        check(32'(irq), 1, "R6", "irq unmasked");
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(32'(rld_flag), 0, "R7", "flag cleared");
        check(32'(irq), 0, "R6", "irq after clear");
        stop_run();

        // R3 R8 R12: armed enable, limit 3, duty 2 and duty 5
        arm_set = 1'b1;
        @(negedge clk);
        arm_set = 1'b0;
        check(32'(arm_o), 1, "R3", "permit set");
        run_en = 1'b1;
        push_run(3, 1, 2, 2, 0, 5, 9, "R8,R12,R3");
        @(negedge clk);
        check(32'(arm_o), 0, "R3", "permit consumed");
        check(32'(rld_flag), 1, "R5", "flag after armed enable");
        stop_run();

        // R11 R7: re-enable without permit, clear collides with set
        run_en = 1'b1;
        flag_clr = 1'b1;
        push_run(3, 1, 2, 2, 0, 5, 9, "R11");
        @(negedge clk);
        flag_clr = 1'b0;
        check(32'(rld_flag), 1, "R7", "set wins over clear");
        stop_run();

        // R9: spacing 0, mid-run update lands at next period
        wr(0, 4, 1'b0);
        wr(3, 1, 1'b1);
        run_en = 1'b1;
        push_run(4, 1, 1, 3, 1, 5, 16, "R9");
        @(negedge clk);
        wr(3, 3, 1'b1);
        repeat (4) @(negedge clk);
        wr(3, 2, 1'b0);
        stop_run();

        // R10: spacing 2, update lands at period 3
        wr(2, 2, 1'b0);
        wr(0, 2, 1'b0);
        wr(3, 0, 1'b1);
        run_en = 1'b1;
        push_run(2, 1, 0, 2, 3, 5, 12, "R10,R12");
        @(negedge clk);
        wr(3, 2, 1'b1);
        stop_run();

        // R13: prescaler code 2 divides the count rate by 4
        wr(2, 0, 1'b0);
        wr(1, 2, 1'b0);
        wr(0, 3, 1'b0);
        wr(3, 1, 1'b1);
        run_en = 1'b1;
        push_run(3, 4, 1, 1, 0, 5, 24, "R13");
        stop_run();

        summary();
        $finish;
    end
endmodule